// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

The block holds a bank of one-time-programmable fuse storage made of several equal macros, each a stack of 32-bit rows. A bit-addressed program port can only turn bits on; once a bit reads 1 it stays 1 until reset. A short table of guarded bit addresses, fixed by parameter, refuses programming. A row-addressed read port returns a whole row. Every successful program raises a row write-back notice, so a neighbour can mirror the array.

On request, a scan sequencer visits each macro's first row and checks a 4-bit integrity marker in bits 31..28. The marker passes when it equals 4'b1010. The scan builds a pass vector in which bit i stands for macro i. As an option, the scan fills a blank marker with the pass pattern before scoring it.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: A flat bit index `b` on `prog_bit_i` addresses row `b/32`, column `b%32`. Programming bit 37 sets bit 5 of row 1.
- R2: A program ORs a single 1 into the array. No operation ever changes a stored 1 to 0, and programming a bit that is already set leaves the row unchanged.
- R3: A program is accepted on a cycle where `prog_valid_i` and `prog_ready_o` are both high. One cycle later `prog_done_o` pulses for one cycle. `prog_ok_o` is then 0 if the bit is in the guarded table or lies beyond the last row, and the array is left untouched. Otherwise `prog_ok_o` is 1.
- R4: `rd_data_o` shows the row addressed by `rd_addr_i` one clock later, as it stood before that edge's write. An out-of-range row reads as 0.
- R5: The scan visits macros from the highest index down to 0, one per clock. It shifts each result in at the LSB, so bit i of `scan_pass_o` is 1 exactly when macro i's first row holds 4'b1010 in bits 31..28.
- R6: If `scan_fill_i` is 1 when the scan is accepted, a first-row marker of 4'b0000 is written to 4'b1010 and scored as a pass. A non-zero marker other than 4'b1010 fails and is not changed. With `scan_fill_i` at 0, no row is written.
- R7: Each successful program, and each marker fill, pulses `wb_valid_o` one cycle later, with `wb_row_o` and `wb_data_o` carrying the row index and the row's new 32-bit value.
- R8: A scan is accepted when `scan_valid_i` and `scan_ready_o` are high. `scan_ready_o` is low while `prog_valid_i` is high, so a program wins a tie. `busy_o` stays high for NUM_MACROS cycles. While `busy_o` is high, both ready outputs are low and requests are ignored.
- R9: Reset clears all rows, then loads the first row of macro i from PRELOAD[32*i +: 32]. All pulse outputs and `scan_pass_o` reset to 0.
- R10: `scan_done_o` pulses in the cycle after the last macro is scored, with `busy_o` low. `scan_pass_o` holds the result until the next scan completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_valid_i | input | 1 | Program request |
| prog_ready_o | output | 1 | Program request can be taken |
| prog_bit_i | input | BIT_W | Flat bit index to program |
| prog_done_o | output | 1 | Program result pulse |
| prog_ok_o | output | 1 | Result of the last program, 1 = bit set |
| rd_addr_i | input | ROW_W | Read row address |
| rd_data_o | output | 32 | Row read data, one cycle latency |
| scan_valid_i | input | 1 | Scan request |
| scan_ready_o | output | 1 | Scan request can be taken |
| scan_fill_i | input | 1 | Fill blank markers during this scan |
| busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | Scan finished pulse |
| scan_pass_o | output | NUM_MACROS | Per-macro marker pass vector |
| wb_valid_o | output | 1 | Row write-back notice |
| wb_row_o | output | ROW_W | Row that changed |
| wb_data_o | output | 32 | New value of that row |

## Verification
The hardest case to reach is a request that arrives while a scan is running. A program pulse made during that time must leave no mark. The bench reaches it by starting a fill scan and raising `prog_valid_i` for exactly one cycle while `busy_o` is high. It then reads the target row and looks for the missing bit. Marker states that reset cannot produce, such as a corrupt nibble on macro 1, come from the preload parameter and from programming bit 31 of that macro's first row. A second program aimed at a guarded bit inside that macro's marker field checks that the guarded table covers the field too.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int unsigned ROW_BITS = 32;
  localparam int unsigned COL_W    = 5;
  localparam int unsigned MARK_LSB = 28;
  localparam logic [3:0]  MARK_OK  = 4'b1010;

  typedef logic [ROW_BITS-1:0] row_t;

  function automatic logic [3:0] mark_of(row_t r);
    return r[MARK_LSB +: 4];
  endfunction
endpackage

// File: rtl/otp_prot_match.sv
module otp_prot_match #(
  parameter int unsigned BIT_W    = 13,
  parameter int unsigned NUM_PROT = 4,
  parameter logic [NUM_PROT*BIT_W-1:0] PROT_BITS = '0
) (
  input  logic [BIT_W-1:0] bit_i,
  output logic             hit_o
);
  logic [NUM_PROT-1:0] eq;

  for (genvar k = 0; k < NUM_PROT; k++) begin : g_cmp
    assign eq[k] = (bit_i == PROT_BITS[k*BIT_W +: BIT_W]);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_fuse_pkg::*;
#(
  parameter int unsigned NUM_MACROS     = 3,
  parameter int unsigned ROWS_PER_MACRO = 64,
  parameter int unsigned NUM_ROWS       = NUM_MACROS * ROWS_PER_MACRO,
  parameter int unsigned ROW_W          = 8,
  parameter logic [NUM_MACROS*ROW_BITS-1:0] PRELOAD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ROW_W-1:0] waddr_i,
  input  row_t             wdata_i,
  input  logic [ROW_W-1:0] caddr_i,
  output row_t             cdata_o,
  input  logic [ROW_W-1:0] raddr_i,
  output row_t             rdata_o
);
  localparam logic [ROW_W:0] ROWS_LIM = (ROW_W+1)'(NUM_ROWS);

  row_t mem [NUM_ROWS];
  row_t rdata_q;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    localparam row_t RST_VAL = (r % ROWS_PER_MACRO == 0) ?
                               PRELOAD[(r / ROWS_PER_MACRO) * ROW_BITS +: ROW_BITS] : '0;
    row_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= RST_VAL;
      else if (we_i && waddr_i == ROW_W'(r))        q <= wdata_i;
    end
    assign mem[r] = q;
  end

  assign cdata_o = ({1'b0, caddr_i} < ROWS_LIM) ? mem[caddr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= ({1'b0, raddr_i} < ROWS_LIM) ? mem[raddr_i] : '0;
  end
  assign rdata_o = rdata_q;

  // Writer must keep every stored 1
  assert_or_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ({1'b0, waddr_i} < ROWS_LIM) && ((wdata_i & mem[waddr_i]) == mem[waddr_i]));
endmodule

// File: rtl/otp_tbit_scan.sv
module otp_tbit_scan
  import otp_fuse_pkg::*;
#(
  parameter int unsigned NUM_MACROS     = 3,
  parameter int unsigned ROWS_PER_MACRO = 64,
  parameter int unsigned ROW_W          = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  fill_i,
  input  row_t                  row_data_i,
  output logic                  busy_o,
  output logic [ROW_W-1:0]      row_addr_o,
  output logic                  we_o,
  output row_t                  wdata_o,
  output logic                  done_o,
  output logic [NUM_MACROS-1:0] pass_o
);
  localparam int unsigned IDX_W = (NUM_MACROS > 1) ? $clog2(NUM_MACROS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MACROS - 1);

  logic                  busy_q, fill_q, done_q;
  logic [IDX_W-1:0]      idx_q;
  logic [NUM_MACROS-1:0] acc_q, acc_d, pass_q;
  logic [3:0]            mark;
  logic                  blank_fill, pass_bit;

  assign mark       = mark_of(row_data_i);
  assign blank_fill = busy_q && fill_q && (mark == 4'h0);
  assign pass_bit   = blank_fill || (mark == MARK_OK);
  assign acc_d      = NUM_MACROS'(acc_q << 1) | NUM_MACROS'(pass_bit);

  assign row_addr_o = ROW_W'(idx_q) * ROW_W'(ROWS_PER_MACRO);
  assign we_o       = blank_fill;
  assign wdata_o    = row_data_i | (row_t'(MARK_OK) << MARK_LSB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fill_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      pass_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q <= acc_d;
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pass_q <= acc_d;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        fill_q <= fill_i;
        idx_q  <= LAST_IDX;
        acc_q  <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign pass_o = pass_q;

  assert_idx_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (idx_q <= LAST_IDX));
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned NUM_MACROS     = 3,
  parameter int unsigned MACRO_BITS     = 2048,
  parameter int unsigned NUM_PROT       = 4,
  parameter int unsigned TOTAL_BITS     = NUM_MACROS * MACRO_BITS,
  parameter int unsigned BIT_W          = $clog2(TOTAL_BITS),
  parameter int unsigned ROW_W          = BIT_W - COL_W,
  parameter logic [NUM_PROT*BIT_W-1:0]        PROT_BITS = {13'd6000, 13'd2077, 13'd100, 13'd5},
  parameter logic [NUM_MACROS*ROW_BITS-1:0]   PRELOAD   = {32'hA000_0001, 32'h5000_0000, 32'h0000_0000}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  prog_valid_i,
  output logic                  prog_ready_o,
  input  logic [BIT_W-1:0]      prog_bit_i,
  output logic                  prog_done_o,
  output logic                  prog_ok_o,
  input  logic [ROW_W-1:0]      rd_addr_i,
  output logic [31:0]           rd_data_o,
  input  logic                  scan_valid_i,
  output logic                  scan_ready_o,
  input  logic                  scan_fill_i,
  output logic                  busy_o,
  output logic                  scan_done_o,
  output logic [NUM_MACROS-1:0] scan_pass_o,
  output logic                  wb_valid_o,
  output logic [ROW_W-1:0]      wb_row_o,
  output logic [31:0]           wb_data_o
);
  localparam int unsigned ROWS_PER_MACRO = MACRO_BITS / ROW_BITS;
  localparam int unsigned NUM_ROWS       = NUM_MACROS * ROWS_PER_MACRO;
  localparam logic [ROW_W:0] ROWS_LIM    = (ROW_W+1)'(NUM_ROWS);

  logic             scan_busy, scan_we, prot_hit;
  logic [ROW_W-1:0] scan_row, prog_row, caddr;
  logic [COL_W-1:0] prog_col;
  row_t             cdata, scan_wdata, wdata;
  logic             prog_fire, scan_fire, prog_good, we;

  logic             done_q, ok_q, wbv_q;
  logic [ROW_W-1:0] wbrow_q;
  row_t             wbdata_q;

  assign prog_row  = prog_bit_i[BIT_W-1:COL_W];
  assign prog_col  = prog_bit_i[COL_W-1:0];

  assign prog_ready_o = !scan_busy;
  assign scan_ready_o = !scan_busy && !prog_valid_i;
  assign prog_fire    = prog_valid_i && prog_ready_o;
  assign scan_fire    = scan_valid_i && scan_ready_o;

  otp_prot_match #(
    .BIT_W(BIT_W), .NUM_PROT(NUM_PROT), .PROT_BITS(PROT_BITS)
  ) u_prot (
    .bit_i (prog_bit_i),
    .hit_o (prot_hit)
  );

  assign prog_good = prog_fire && !prot_hit && ({1'b0, prog_row} < ROWS_LIM);
  assign caddr     = scan_busy ? scan_row : prog_row;
  assign we        = scan_we || prog_good;
  assign wdata     = scan_busy ? scan_wdata : (cdata | (row_t'(1) << prog_col));

  otp_fuse_array #(
    .NUM_MACROS(NUM_MACROS), .ROWS_PER_MACRO(ROWS_PER_MACRO), .NUM_ROWS(NUM_ROWS),
    .ROW_W(ROW_W), .PRELOAD(PRELOAD)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (caddr),
    .wdata_i (wdata),
    .caddr_i (caddr),
    .cdata_o (cdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  otp_tbit_scan #(
    .NUM_MACROS(NUM_MACROS), .ROWS_PER_MACRO(ROWS_PER_MACRO), .ROW_W(ROW_W)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (scan_fire),
    .fill_i     (scan_fill_i),
    .row_data_i (cdata),
    .busy_o     (scan_busy),
    .row_addr_o (scan_row),
    .we_o       (scan_we),
    .wdata_o    (scan_wdata),
    .done_o     (scan_done_o),
    .pass_o     (scan_pass_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      wbv_q    <= 1'b0;
      wbrow_q  <= '0;
      wbdata_q <= '0;
    end else begin
      done_q <= prog_fire;
      if (prog_fire) ok_q <= prog_good;
      wbv_q <= we;
      if (we) begin
        wbrow_q  <= caddr;
        wbdata_q <= wdata;
      end
    end
  end

  assign busy_o      = scan_busy;
  assign prog_done_o = done_q;
  assign prog_ok_o   = ok_q;
  assign wb_valid_o  = wbv_q;
  assign wb_row_o    = wbrow_q;
  assign wb_data_o   = wbdata_q;

  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!prog_ready_o && !scan_ready_o));
  assert_no_prog_in_scan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !prog_done_o);
  assert_refused_no_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_done_o && !prog_ok_o) |-> !wb_valid_o);
  assert_wb_row_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> ({1'b0, wb_row_o} < ROWS_LIM));
endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;
  localparam int NM    = 3;
  localparam int RPM   = 64;
  localparam int NROWS = NM * RPM;
  localparam int BW    = 13;
  localparam int RW    = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic          prog_valid_i = 0;
  logic [BW-1:0] prog_bit_i = '0;
  logic [RW-1:0] rd_addr_i = '0;
  logic          scan_valid_i = 0, scan_fill_i = 0;
  logic          prog_ready_o, prog_done_o, prog_ok_o, scan_ready_o, busy_o, scan_done_o, wb_valid_o;
  logic [31:0]   rd_data_o, wb_data_o;
  logic [NM-1:0] scan_pass_o;
  logic [RW-1:0] wb_row_o;

  otp_fuse_ctrl #(
    .NUM_MACROS(NM), .MACRO_BITS(2048), .NUM_PROT(4),
    .PROT_BITS({13'd6000, 13'd2077, 13'd100, 13'd5}),
    .PRELOAD({32'hA000_0001, 32'h5000_0000, 32'h0000_0000})
  ) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  // behavioural reference
  int          prot_q[$] = '{5, 100, 2077, 6000};
  logic [31:0] m_mem [NROWS];
  bit          m_busy = 0, m_fill = 0;
  int          m_idx = 0;
  logic [NM-1:0] m_acc = '0;
  logic [31:0] e_rd = 0, e_wbdata = 0;
  int          e_wbrow = 0;
  bit          e_pdone = 0, e_pok = 0, e_sdone = 0, e_wbv = 0;
  logic [NM-1:0] e_pass = '0;

  initial begin
    foreach (m_mem[i]) m_mem[i] = 32'h0;
    m_mem[RPM]   = 32'h5000_0000;
    m_mem[2*RPM] = 32'hA000_0001;
  end

  always @(posedge clk_i) if (rst_ni) begin
    int r, b;
    bit p, ok;
    e_rd = (int'(rd_addr_i) < NROWS) ? m_mem[rd_addr_i] : 32'h0;
    e_pdone = 0; e_sdone = 0; e_wbv = 0;
    if (m_busy) begin
      r = m_idx * RPM;
      p = (m_mem[r][31:28] == 4'hA);
      if (m_fill && m_mem[r][31:28] == 4'h0) begin
        m_mem[r] = m_mem[r] | 32'hA000_0000;
        p = 1; e_wbv = 1; e_wbrow = r; e_wbdata = m_mem[r];
      end
      m_acc = {m_acc[NM-2:0], p};
      if (m_idx == 0) begin m_busy = 0; e_sdone = 1; e_pass = m_acc; end
      else m_idx--;
    end else if (prog_valid_i) begin
      b = int'(prog_bit_i);
      ok = (b / 32) < NROWS;
      foreach (prot_q[i]) if (prot_q[i] == b) ok = 0;
      e_pdone = 1; e_pok = ok;
      if (ok) begin
        m_mem[b/32] = m_mem[b/32] | (32'h1 << (b % 32));
        e_wbv = 1; e_wbrow = b / 32; e_wbdata = m_mem[b/32];
      end
    end else if (scan_valid_i) begin
      m_busy = 1; m_idx = NM - 1; m_fill = scan_fill_i; m_acc = '0;
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done_flag) begin
    cmp(rd_data_o, e_rd, "R4", "rd_data");
    cmp(32'(busy_o), 32'(m_busy), "R8", "busy");
    cmp(32'(prog_ready_o), 32'(!m_busy), "R8", "prog_ready");
    cmp(32'(scan_ready_o), 32'(!m_busy && !prog_valid_i), "R8", "scan_ready");
    cmp(32'(prog_done_o), 32'(e_pdone), "R3", "prog_done");
    if (e_pdone) cmp(32'(prog_ok_o), 32'(e_pok), "R3", "prog_ok");
    cmp(32'(scan_done_o), 32'(e_sdone), "R10", "scan_done");
    cmp(32'(scan_pass_o), 32'(e_pass), "R5", "scan_pass");
    cmp(32'(wb_valid_o), 32'(e_wbv), "R7", "wb_valid");
    if (e_wbv) begin
      cmp(32'(wb_row_o), 32'(e_wbrow), "R7", "wb_row");
      cmp(wb_data_o, e_wbdata, "R7", "wb_data");
    end
  end

  task automatic prog(input int b);
    @(negedge clk_i); #1 prog_valid_i = 1; prog_bit_i = BW'(b);
    @(negedge clk_i); #1 prog_valid_i = 0;
  endtask

  task automatic run_scan(input bit fill);
    @(negedge clk_i); #1 scan_valid_i = 1; scan_fill_i = fill;
    @(negedge clk_i); #1 scan_valid_i = 0;
    repeat (NM + 1) @(negedge clk_i);
  endtask

  task automatic read_row(input int a, input logic [31:0] exp, input string req);
    @(negedge clk_i); #1 rd_addr_i = RW'(a);
    @(negedge clk_i);
    cmp(rd_data_o, exp, req, $sformatf("row %0d", a));
  endtask

  task automatic summary();
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    // R9 reset state
    cmp(32'(prog_done_o), 0, "R9", "prog_done after reset");
    cmp(32'(scan_pass_o), 0, "R9", "scan_pass after reset");
    cmp(32'(wb_valid_o), 0, "R9", "wb_valid after reset");
    read_row(0, 32'h0, "R9");
    read_row(64, 32'h5000_0000, "R9");
    read_row(128, 32'hA000_0001, "R9");
    read_row(255, 32'h0, "R4");

    // R5 scan without fill
    run_scan(0);
    cmp(32'(scan_pass_o), 32'b100, "R5", "pass no fill");
    read_row(0, 32'h0, "R6");

    // R1 / R2 programming
    prog(37);
    read_row(1, 32'h0000_0020, "R1");
    prog(37);
    prog(63);
    read_row(1, 32'h8000_0020, "R2");

    // R3 guarded and out of range
    prog(5);
    read_row(0, 32'h0, "R3");
    prog(6100);
    read_row(190, 32'h0010_0000, "R1");
    prog(6200);

    // R6 / R8 fill scan with a program pulse during busy
    @(negedge clk_i); #1 scan_valid_i = 1; scan_fill_i = 1;
    @(negedge clk_i); #1 scan_valid_i = 0; prog_valid_i = 1; prog_bit_i = BW'(0);
    @(negedge clk_i); #1 prog_valid_i = 0;
    repeat (NM + 1) @(negedge clk_i);
    cmp(32'(scan_pass_o), 32'b101, "R6", "pass with fill");
    read_row(0, 32'hA000_0000, "R8");
    read_row(64, 32'h5000_0000, "R6");

    // Corrupt macro 1 marker further, guarded marker bit
    prog(2079);
    prog(2077);
    read_row(64, 32'hD000_0000, "R6");
    run_scan(1);
    cmp(32'(scan_pass_o), 32'b101, "R5", "pass after corrupt");
    read_row(64, 32'hD000_0000, "R2");

    // Tie: program and scan together, program first
    @(negedge clk_i); #1 prog_valid_i = 1; prog_bit_i = BW'(70); scan_valid_i = 1; scan_fill_i = 0;
    @(negedge clk_i); #1 prog_valid_i = 0;
    @(negedge clk_i); #1 scan_valid_i = 0;
    repeat (NM + 2) @(negedge clk_i);
    read_row(2, 32'h0000_0040, "R8");
    cmp(32'(scan_pass_o), 32'b101, "R10", "pass held");
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule